// File: doc/BRIEF.md
# ATA PIO Sector Transfer Engine

This block moves whole 512-byte sectors between byte streams and a CompactFlash card on an 8-bit ATA PIO bus. It takes one command at a time. The command gives the direction, a 28-bit logical block address and a sector count. A count of zero moves 256 sectors.

The engine works through a fixed sequence of bus cycles:
- It writes the task-file registers.
- Before each sector it polls the status register until the card asks for data.
- It moves the sector one byte per strobe.
- After a write it waits for the card to finish.
- It closes with two status reads and a one-cycle `done` pulse, with `err` marking a failed transfer.

A 10 ms tick bounds every polling window. Every bus cycle has a setup phase, a strobe-low phase and a strobe-high phase. Each phase lasts a parameterised number of clocks, and each must be at least one clock.

Read bytes leave on a valid/ready stream. Write bytes arrive on a second valid/ready stream. The bus waits on either side rather than buffering.

Top module: `ata_sector_mover`

## Requirements
- R1: After a command is accepted, the first four bus cycles are register writes. They carry the sector count to address 2, then LBA bits 7:0 to address 3, bits 15:8 to address 4 and bits 23:16 to address 5.
- R2: The fifth bus cycle writes 0xE0 OR LBA bits 27:24 to address 6. The sixth writes the command byte to address 7: 0x20 for a read, 0x30 for a write.
- R3: Before every sector the engine reads status at address 7 repeatedly until bit 7 (busy) is 0 and bit 3 (data request) is 1. No data-register cycle happens before that status value is seen.
- R4: If a polling window has seen 100 ticks and the next status read is still not ready, the command ends with `done` and `err` both high. No data-register cycle takes place.
- R5: Each sector moves as exactly 512 data-register cycles at address 0. Bytes go out in stream order: even byte first, then odd byte, across 256 pairs.
- R6: A read byte stays on `rd_data` with `rd_valid` high until `rd_ready` is seen. No further bus cycle starts while a byte is waiting.
- R7: A write strobe at address 0 starts only after a byte is taken from `wr_data`/`wr_valid`. The bytes appear on the bus in the order they were taken.
- R8: The bus access rules are as follows:
  - In a register read, chip select is low and the data bus is not driven while the read strobe is low.
  - In a register write, chip select is low and the data bus is driven while the write strobe is low.
  - The two strobes are never low together.
- R9: After the last sector of a write, the engine polls address 7 until bit 7 is 0. If bit 0 (error) is then 1, the command ends with `err`, and no further bus cycle takes place.
- R10: A transfer that succeeds ends with one read at address 6 (alternate status), then one read at address 7, then `done` with `err` low.
- R11: `cmd_ready` is high only while no command is in progress. Chip select is high whenever `cmd_ready` is high.
- R12: Each strobe stays low for at least `LOW_CYC` clocks. Chip select is low for at least `SETUP_CYC` clocks before the strobe falls.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| tick | input | 1 | One-clock pulse every 10 ms |
| cmd_valid | input | 1 | Command offered |
| cmd_ready | output | 1 | Engine idle, command taken when both high |
| cmd_write | input | 1 | 1 = write sectors, 0 = read sectors |
| cmd_lba | input | 28 | Logical block address |
| cmd_count | input | 8 | Sector count, 0 means 256 |
| wr_data | input | 8 | Write stream byte |
| wr_valid | input | 1 | Write stream byte valid |
| wr_ready | output | 1 | Engine takes the write byte |
| rd_data | output | 8 | Read stream byte |
| rd_valid | output | 1 | Read stream byte valid |
| rd_ready | input | 1 | Downstream takes the read byte |
| done | output | 1 | One-cycle completion pulse |
| err | output | 1 | Failure flag, valid with done |
| ata_addr | output | 3 | Register address on the bus |
| ata_cs0_n | output | 1 | Chip select, active low |
| ata_iord_n | output | 1 | Read strobe, active low |
| ata_iowr_n | output | 1 | Write strobe, active low |
| ata_dout | output | 8 | Data driven to the card |
| ata_doe | output | 1 | Output enable for ata_dout |
| ata_din | input | 8 | Data returned by the card |

## Verification
The assertions assume the card keeps `ata_din` steady while the read strobe is low. They also assume `tick` is a single-clock pulse and that the command fields hold while `cmd_valid` waits for `cmd_ready`. The bench's card model meets these assumptions:
- It derives `ata_din` only from the address and from counters that it updates after a strobe rises.
- It produces a tick on every fourth clock, and only during the timeout scenario.
- It holds the command fields until acceptance.

The stream sides are throttled by a shift-register pattern, so stalls land both during and between bus cycles.

// File: rtl/ata_mover_pkg.sv
package ata_mover_pkg;
  localparam int          LBA_BITS    = 28;
  localparam logic [2:0]  RA_DATA     = 3'd0;
  localparam logic [2:0]  RA_COUNT    = 3'd2;
  localparam logic [2:0]  RA_LBA_LO   = 3'd3;
  localparam logic [2:0]  RA_LBA_MID  = 3'd4;
  localparam logic [2:0]  RA_LBA_HI   = 3'd5;
  localparam logic [2:0]  RA_DEVSEL   = 3'd6;
  localparam logic [2:0]  RA_CMDSTAT  = 3'd7;
  localparam logic [2:0]  RA_ALTSTAT  = 3'd6;  // low three bits of 0xE
  localparam logic [7:0]  OP_RD_SECT  = 8'h20;
  localparam logic [7:0]  OP_WR_SECT  = 8'h30;
  localparam logic [7:0]  DEVSEL_BASE = 8'hE0;
  localparam int          SB_BUSY     = 7;
  localparam int          SB_DREQ     = 3;
  localparam int          SB_FAULT    = 0;

  typedef enum logic [3:0] {
    SQ_IDLE, SQ_ISSUE, SQ_POLL, SQ_RDATA, SQ_RHOLD,
    SQ_WGET, SQ_WPUT, SQ_NEXT, SQ_WFIN, SQ_TAIL
  } seq_t;

  typedef enum logic [1:0] {PH_IDLE, PH_SETUP, PH_LOW, PH_HIGH} phase_t;
endpackage

// File: rtl/ata_issue_sel.sv
module ata_issue_sel
  import ata_mover_pkg::*;
(
  input  logic [2:0]          step,
  input  logic                is_write,
  input  logic [LBA_BITS-1:0] lba,
  input  logic [7:0]          count,
  output logic [2:0]          reg_addr,
  output logic [7:0]          reg_data
);
  always_comb begin
    case (step)
      3'd0:    begin reg_addr = RA_COUNT;   reg_data = count;                     end
      3'd1:    begin reg_addr = RA_LBA_LO;  reg_data = lba[7:0];                  end
      3'd2:    begin reg_addr = RA_LBA_MID; reg_data = lba[15:8];                 end
      3'd3:    begin reg_addr = RA_LBA_HI;  reg_data = lba[23:16];                end
      3'd4:    begin reg_addr = RA_DEVSEL;  reg_data = DEVSEL_BASE | {4'h0, lba[27:24]}; end
      default: begin reg_addr = RA_CMDSTAT; reg_data = is_write ? OP_WR_SECT : OP_RD_SECT; end
    endcase
  end
endmodule

// File: rtl/ata_tick_timer.sv
module ata_tick_timer #(
  parameter int LIMIT = 100
) (
  input  logic clk,
  input  logic rst,
  input  logic load,
  input  logic tick,
  output logic expired
);
  localparam int CW = $clog2(LIMIT + 1);
  localparam logic [CW-1:0] LIM = CW'(LIMIT);

  logic [CW-1:0] cnt;

  always_ff @(posedge clk) begin
    if (rst || load)               cnt <= '0;
    else if (tick && cnt != LIM)   cnt <= cnt + 1'b1;
  end

  assign expired = (cnt == LIM);

  assert_timer_bound_R4: assert property (@(posedge clk) disable iff (rst)
    cnt <= LIM);
endmodule

// File: rtl/ata_pio_cycle.sv
module ata_pio_cycle
  import ata_mover_pkg::*;
#(
  parameter int SETUP_CYC = 2,
  parameter int LOW_CYC   = 3,
  parameter int HIGH_CYC  = 2,
  parameter int ADDR_W    = 3,
  parameter int DATA_W    = 8
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              start,
  input  logic              is_write,
  input  logic [ADDR_W-1:0] addr,
  input  logic [DATA_W-1:0] wdata,
  output logic              done,
  output logic [DATA_W-1:0] rdata,
  output logic [ADDR_W-1:0] bus_addr,
  output logic              cs_n,
  output logic              iord_n,
  output logic              iowr_n,
  output logic [DATA_W-1:0] bus_dout,
  output logic              bus_doe,
  input  logic [DATA_W-1:0] bus_din
);
  localparam int MAX_A = (SETUP_CYC > LOW_CYC) ? SETUP_CYC : LOW_CYC;
  localparam int MAX_C = (MAX_A > HIGH_CYC) ? MAX_A : HIGH_CYC;
  localparam int CW    = $clog2(MAX_C + 1);
  localparam logic [CW-1:0] SETUP_LD = CW'(SETUP_CYC - 1);
  localparam logic [CW-1:0] LOW_LD   = CW'(LOW_CYC - 1);
  localparam logic [CW-1:0] HIGH_LD  = CW'(HIGH_CYC - 1);

  phase_t        ph;
  logic [CW-1:0] cnt;
  logic          wr_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      ph <= PH_IDLE; cnt <= '0; wr_q <= 1'b0; done <= 1'b0;
      cs_n <= 1'b1; iord_n <= 1'b1; iowr_n <= 1'b1; bus_doe <= 1'b0;
      bus_addr <= '0; bus_dout <= '0; rdata <= '0;
    end else begin
      done <= 1'b0;
      case (ph)
        PH_IDLE: if (start) begin
          cs_n <= 1'b0; bus_addr <= addr; bus_dout <= wdata;
          bus_doe <= is_write; wr_q <= is_write;
          cnt <= SETUP_LD; ph <= PH_SETUP;
        end
        PH_SETUP: if (cnt == '0) begin
          iord_n <= wr_q; iowr_n <= ~wr_q; cnt <= LOW_LD; ph <= PH_LOW;
        end else cnt <= cnt - 1'b1;
        PH_LOW: if (cnt == '0) begin
          rdata <= bus_din; iord_n <= 1'b1; iowr_n <= 1'b1;
          cnt <= HIGH_LD; ph <= PH_HIGH;
        end else cnt <= cnt - 1'b1;
        default: if (cnt == '0) begin
          cs_n <= 1'b1; bus_doe <= 1'b0; done <= 1'b1; ph <= PH_IDLE;
        end else cnt <= cnt - 1'b1;
      endcase
    end
  end

  assert_strobes_exclusive_R8: assert property (@(posedge clk) disable iff (rst)
    !(!iord_n && !iowr_n));
  assert_cs_under_strobe_R8: assert property (@(posedge clk) disable iff (rst)
    (!iord_n || !iowr_n) |-> !cs_n);
  assert_write_driven_R8: assert property (@(posedge clk) disable iff (rst)
    !iowr_n |-> bus_doe);
  assert_write_data_steady_R8: assert property (@(posedge clk) disable iff (rst)
    (!iowr_n && $past(!iowr_n)) |-> $stable(bus_dout));
  assert_read_floats_R8: assert property (@(posedge clk) disable iff (rst)
    !iord_n |-> !bus_doe);
endmodule

// File: rtl/ata_sector_mover.sv
module ata_sector_mover
  import ata_mover_pkg::*;
#(
  parameter int SETUP_CYC     = 2,
  parameter int LOW_CYC       = 3,
  parameter int HIGH_CYC      = 2,
  parameter int TIMEOUT_TICKS = 100,
  parameter int SECTOR_BYTES  = 512,
  parameter int CNT_W         = 8
) (
  input  logic                clk,
  input  logic                rst,
  input  logic                tick,
  input  logic                cmd_valid,
  output logic                cmd_ready,
  input  logic                cmd_write,
  input  logic [LBA_BITS-1:0] cmd_lba,
  input  logic [CNT_W-1:0]    cmd_count,
  input  logic [7:0]          wr_data,
  input  logic                wr_valid,
  output logic                wr_ready,
  output logic [7:0]          rd_data,
  output logic                rd_valid,
  input  logic                rd_ready,
  output logic                done,
  output logic                err,
  output logic [2:0]          ata_addr,
  output logic                ata_cs0_n,
  output logic                ata_iord_n,
  output logic                ata_iowr_n,
  output logic [7:0]          ata_dout,
  output logic                ata_doe,
  input  logic [7:0]          ata_din
);
  localparam int BYTE_W = $clog2(SECTOR_BYTES);
  localparam logic [BYTE_W-1:0] LAST_BYTE = BYTE_W'(SECTOR_BYTES - 1);
  localparam logic [CNT_W:0]    FULL_RUN  = {1'b1, {CNT_W{1'b0}}};

  seq_t                st;
  logic                pend, tail2, op_wr;
  logic [2:0]          step;
  logic [LBA_BITS-1:0] lba_q;
  logic [CNT_W-1:0]    cnt_q;
  logic [CNT_W:0]      sec_left;
  logic [BYTE_W-1:0]   byte_idx;
  logic                bc_start, bc_wr, bc_done;
  logic [2:0]          bc_addr;
  logic [7:0]          bc_wdata, bc_rdata;
  logic                tmr_load, tmr_exp;
  logic [2:0]          iss_addr;
  logic [7:0]          iss_data;
  logic                stat_go, stat_idle, stat_fault;

  ata_issue_sel u_issue (
    .step(step), .is_write(op_wr), .lba(lba_q), .count(8'(cnt_q)),
    .reg_addr(iss_addr), .reg_data(iss_data)
  );

  ata_tick_timer #(.LIMIT(TIMEOUT_TICKS)) u_timer (
    .clk(clk), .rst(rst), .load(tmr_load), .tick(tick), .expired(tmr_exp)
  );

  ata_pio_cycle #(.SETUP_CYC(SETUP_CYC), .LOW_CYC(LOW_CYC), .HIGH_CYC(HIGH_CYC),
                  .ADDR_W(3), .DATA_W(8)) u_cycle (
    .clk(clk), .rst(rst), .start(bc_start), .is_write(bc_wr), .addr(bc_addr),
    .wdata(bc_wdata), .done(bc_done), .rdata(bc_rdata), .bus_addr(ata_addr),
    .cs_n(ata_cs0_n), .iord_n(ata_iord_n), .iowr_n(ata_iowr_n),
    .bus_dout(ata_dout), .bus_doe(ata_doe), .bus_din(ata_din)
  );

  assign stat_go    = !bc_rdata[SB_BUSY] && bc_rdata[SB_DREQ];
  assign stat_idle  = !bc_rdata[SB_BUSY];
  assign stat_fault = bc_rdata[SB_FAULT];
  assign cmd_ready  = (st == SQ_IDLE);
  assign wr_ready   = (st == SQ_WGET);

  always_ff @(posedge clk) begin
    if (rst) begin
      st <= SQ_IDLE; pend <= 1'b0; tail2 <= 1'b0; op_wr <= 1'b0; step <= '0;
      lba_q <= '0; cnt_q <= '0; sec_left <= '0; byte_idx <= '0;
      bc_start <= 1'b0; bc_wr <= 1'b0; bc_addr <= '0; bc_wdata <= '0;
      tmr_load <= 1'b0; rd_data <= '0; rd_valid <= 1'b0; done <= 1'b0; err <= 1'b0;
    end else begin
      bc_start <= 1'b0; tmr_load <= 1'b0; done <= 1'b0; err <= 1'b0;
      case (st)
        SQ_IDLE: if (cmd_valid) begin
          op_wr <= cmd_write; lba_q <= cmd_lba; cnt_q <= cmd_count;
          sec_left <= (cmd_count == '0) ? FULL_RUN : {1'b0, cmd_count};
          step <= '0; pend <= 1'b0; st <= SQ_ISSUE;
        end
        SQ_ISSUE: if (!pend) begin
          bc_start <= 1'b1; bc_wr <= 1'b1; bc_addr <= iss_addr; bc_wdata <= iss_data; pend <= 1'b1;
        end else if (bc_done) begin
          pend <= 1'b0;
          if (step == 3'd5) begin st <= SQ_POLL; tmr_load <= 1'b1; end
          else step <= step + 1'b1;
        end
        SQ_POLL: if (!pend) begin
          bc_start <= 1'b1; bc_wr <= 1'b0; bc_addr <= RA_CMDSTAT; pend <= 1'b1;
        end else if (bc_done) begin
          pend <= 1'b0;
          if (stat_go) st <= op_wr ? SQ_WGET : SQ_RDATA;
          else if (tmr_exp) begin st <= SQ_IDLE; done <= 1'b1; err <= 1'b1; end
        end
        SQ_RDATA: if (!pend) begin
          bc_start <= 1'b1; bc_wr <= 1'b0; bc_addr <= RA_DATA; pend <= 1'b1;
        end else if (bc_done) begin
          pend <= 1'b0; rd_data <= bc_rdata; rd_valid <= 1'b1; st <= SQ_RHOLD;
        end
        SQ_RHOLD: if (rd_ready) begin
          rd_valid <= 1'b0; st <= SQ_NEXT;
        end
        SQ_WGET: if (wr_valid) begin
          bc_start <= 1'b1; bc_wr <= 1'b1; bc_addr <= RA_DATA; bc_wdata <= wr_data;
          pend <= 1'b1; st <= SQ_WPUT;
        end
        SQ_WPUT: if (bc_done) begin
          pend <= 1'b0; st <= SQ_NEXT;
        end
        SQ_NEXT: if (byte_idx == LAST_BYTE) begin
          byte_idx <= '0;
          if (sec_left == 1) begin
            tail2 <= 1'b0;
            if (op_wr) begin st <= SQ_WFIN; tmr_load <= 1'b1; end
            else st <= SQ_TAIL;
          end else begin
            sec_left <= sec_left - 1'b1; tmr_load <= 1'b1; st <= SQ_POLL;
          end
        end else begin
          byte_idx <= byte_idx + 1'b1;
          st <= op_wr ? SQ_WGET : SQ_RDATA;
        end
        SQ_WFIN: if (!pend) begin
          bc_start <= 1'b1; bc_wr <= 1'b0; bc_addr <= RA_CMDSTAT; pend <= 1'b1;
        end else if (bc_done) begin
          pend <= 1'b0;
          if (stat_idle) begin
            if (stat_fault) begin st <= SQ_IDLE; done <= 1'b1; err <= 1'b1; end
            else st <= SQ_TAIL;
          end else if (tmr_exp) begin st <= SQ_IDLE; done <= 1'b1; err <= 1'b1; end
        end
        default: if (!pend) begin
          bc_start <= 1'b1; bc_wr <= 1'b0; bc_addr <= tail2 ? RA_CMDSTAT : RA_ALTSTAT; pend <= 1'b1;
        end else if (bc_done) begin
          pend <= 1'b0;
          if (tail2) begin st <= SQ_IDLE; done <= 1'b1; end
          else tail2 <= 1'b1;
        end
      endcase
    end
  end

  assert_idle_bus_quiet_R11: assert property (@(posedge clk) disable iff (rst)
    cmd_ready |-> ata_cs0_n);
  assert_read_byte_held_R6: assert property (@(posedge clk) disable iff (rst)
    (rd_valid && !rd_ready) |=> (rd_valid && $stable(rd_data)));
  assert_held_byte_blocks_bus_R6: assert property (@(posedge clk) disable iff (rst)
    rd_valid |-> (ata_iord_n && ata_iowr_n));
  assert_err_only_at_end_R4: assert property (@(posedge clk) disable iff (rst)
    err |-> done);
  assert_done_single_R10: assert property (@(posedge clk) disable iff (rst)
    done |=> !done);
endmodule

// File: tb/ata_sector_mover_tb.sv
`timescale 1ns/1ps
module ata_sector_mover_tb;
  logic clk = 1'b0;
  always #2.5 clk = ~clk;

  logic rst = 1'b1, tick = 1'b0, cmd_valid = 1'b0, cmd_write = 1'b0;
  logic [27:0] cmd_lba = '0;
  logic [7:0]  cmd_count = '0, wr_data = '0, rd_data, ata_dout, ata_din;
  logic wr_valid = 1'b0, wr_ready, rd_valid, rd_ready = 1'b0, done, err, cmd_ready;
  logic [2:0] ata_addr;
  logic ata_cs0_n, ata_iord_n, ata_iowr_n, ata_doe;

  ata_sector_mover u_dut (
    .clk(clk), .rst(rst), .tick(tick), .cmd_valid(cmd_valid), .cmd_ready(cmd_ready),
    .cmd_write(cmd_write), .cmd_lba(cmd_lba), .cmd_count(cmd_count),
    .wr_data(wr_data), .wr_valid(wr_valid), .wr_ready(wr_ready),
    .rd_data(rd_data), .rd_valid(rd_valid), .rd_ready(rd_ready),
    .done(done), .err(err), .ata_addr(ata_addr), .ata_cs0_n(ata_cs0_n),
    .ata_iord_n(ata_iord_n), .ata_iowr_n(ata_iowr_n), .ata_dout(ata_dout),
    .ata_doe(ata_doe), .ata_din(ata_din)
  );

  int checks = 0, errors = 0;

  task automatic chk(input bit ok, input string req, input string what,
                     input longint act, input longint exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s: actual 0x%0h expected 0x%0h", req, what, act, exp);
    end
  endtask

  function automatic logic [7:0] rd_pat(input int k);
    return 8'((k * 13) ^ (k >> 8) ^ 8'h5A);
  endfunction
  function automatic logic [7:0] wr_pat(input int k);
    return 8'(k * 29 + 7 + (k >> 9));
  endfunction

  // card model state
  int busy_left = 0, busy_reload = 0, bytes_done = 0, total = 512, rd_ptr = 0;
  logic [7:0] final_stat = 8'h50;
  assign ata_din = (ata_addr == 3'd0) ? rd_pat(rd_ptr) :
                   (busy_left > 0) ? 8'h80 : (bytes_done < total) ? 8'h58 : final_stat;

  // access log
  bit         lg_wr   [2048];
  logic [2:0] lg_addr [2048];
  logic [7:0] lg_data [2048];
  int lg_n = 0;

  int low_cnt = 0, setup_cnt = 0, min_low = 1000, min_setup = 1000, viol = 0;
  bit prev_low = 0, prev_w = 0, had = 0;
  logic [7:0] cap = '0;
  logic [2:0] a_cap = '0;

  always @(negedge clk) if (!rst) begin
    if (!ata_iord_n || !ata_iowr_n) begin
      if (!had) begin
        if (setup_cnt < min_setup) min_setup = setup_cnt;
        had = 1;
      end
      low_cnt++; prev_low = 1; prev_w = !ata_iowr_n; a_cap = ata_addr;
      cap = ata_iowr_n ? ata_din : ata_dout;
      if (ata_cs0_n) viol++;
      if (!ata_iowr_n && !ata_doe) viol++;
      if (!ata_iord_n && ata_doe) viol++;
      if (!ata_iord_n && !ata_iowr_n) viol++;
    end else begin
      if (prev_low) begin
        if (low_cnt < min_low) min_low = low_cnt;
        if (lg_n < 2048) begin
          lg_wr[lg_n] = prev_w; lg_addr[lg_n] = a_cap; lg_data[lg_n] = cap; lg_n++;
        end
        if (a_cap == 3'd0) begin
          if (!prev_w) rd_ptr++;
          bytes_done++;
          if (bytes_done % 512 == 0 && bytes_done < total) busy_left = busy_reload;
        end else if (a_cap == 3'd7 && !prev_w && busy_left > 0) busy_left--;
      end
      prev_low = 0; low_cnt = 0;
      if (!ata_cs0_n && !had) setup_cnt++;
    end
    if (ata_cs0_n) begin setup_cnt = 0; had = 0; end
  end

  // stream sides
  logic [15:0] lf = 16'hACE1;
  bit bp_on = 0;
  int rcv_cnt = 0, rcv_bad = 0, hold_bad = 0, stalls = 0, wr_idx = 0;
  bit prev_hold = 0;
  logic [7:0] prev_data = '0;

  always @(negedge clk) begin
    lf = {lf[14:0], lf[15] ^ lf[13] ^ lf[12] ^ lf[10]};
    if (prev_hold && !(rd_valid && rd_data == prev_data)) hold_bad++;
    rd_ready = bp_on ? (lf[0] | lf[3]) : 1'b1;
    if (rd_valid && !rd_ready) stalls++;
    if (rd_valid && rd_ready) begin
      if (rd_data != rd_pat(rcv_cnt)) rcv_bad++;
      rcv_cnt++;
    end
    prev_hold = rd_valid && !rd_ready;
    prev_data = rd_data;
    wr_data  = wr_pat(wr_idx);
    wr_valid = bp_on ? (lf[1] | lf[5]) : 1'b1;
    if (wr_valid && wr_ready) wr_idx++;
  end

  // tick source
  bit tick_en = 0;
  int tdiv = 0, ticks = 0;
  always @(negedge clk) begin
    tdiv++;
    tick = tick_en && (tdiv % 4 == 0);
    if (tick) ticks++;
  end

  // watchdog
  int cyc = 0;
  always @(posedge clk) begin
    cyc++;
    if (cyc > 190000) begin
      errors++; checks++;
      $display("FAIL watchdog: actual %0d cycles expected completion", cyc);
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  task automatic dev_setup(input int first_busy, input int reload, input int sectors,
                           input logic [7:0] fin);
    busy_left = first_busy; busy_reload = reload; total = sectors * 512;
    final_stat = fin; bytes_done = 0; rd_ptr = 0; lg_n = 0;
    rcv_cnt = 0; rcv_bad = 0; hold_bad = 0; stalls = 0; wr_idx = 0;
  endtask

  task automatic run_cmd(input bit w, input logic [27:0] lba, input logic [7:0] cnt,
                         output bit e, output bit seen_busy, output bit finished);
    @(negedge clk);
    cmd_write = w; cmd_lba = lba; cmd_count = cnt; cmd_valid = 1'b1;
    while (!cmd_ready) @(negedge clk);
    @(negedge clk);
    cmd_valid = 1'b0;
    seen_busy = 0; finished = 0; e = 0;
    for (int i = 0; i < 60000; i++) begin
      if (done) begin finished = 1; e = err; break; end
      if (!cmd_ready) seen_busy = 1;
      @(negedge clk);
    end
  endtask

  function automatic int count_data(input bit w);
    int n = 0;
    for (int i = 0; i < lg_n; i++) if (lg_addr[i] == 3'd0 && lg_wr[i] == w) n++;
    return n;
  endfunction

  task automatic check_issue(input logic [27:0] lba, input logic [7:0] cnt, input logic [7:0] op);
    bit ok = (lg_n > 5);
    ok &= lg_wr[0] && lg_addr[0] == 3'd2 && lg_data[0] == cnt;
    ok &= lg_wr[1] && lg_addr[1] == 3'd3 && lg_data[1] == lba[7:0];
    ok &= lg_wr[2] && lg_addr[2] == 3'd4 && lg_data[2] == lba[15:8];
    ok &= lg_wr[3] && lg_addr[3] == 3'd5 && lg_data[3] == lba[23:16];
    chk(ok, "R1", "task-file writes", {lg_addr[0], lg_addr[3], lg_data[1]}, {3'd2, 3'd5, lba[7:0]});
    chk(lg_wr[4] && lg_addr[4] == 3'd6 && lg_data[4] == (8'hE0 | {4'h0, lba[27:24]}),
        "R2", "device select byte", lg_data[4], 8'hE0 | {4'h0, lba[27:24]});
    chk(lg_wr[5] && lg_addr[5] == 3'd7 && lg_data[5] == op, "R2", "command byte", lg_data[5], op);
  endtask

  task automatic t_reset();
    @(negedge clk);
    chk(cmd_ready && ata_cs0_n && ata_iord_n && ata_iowr_n && !ata_doe && !done && !rd_valid,
        "R11", "idle state after reset",
        {cmd_ready, ata_cs0_n, ata_iord_n, ata_iowr_n, ata_doe, done, rd_valid}, 7'b1111000);
  endtask

  task automatic t_read_one();
    bit e, b, f;
    int first;
    dev_setup(3, 2, 1, 8'h50); bp_on = 1;
    run_cmd(1'b0, 28'hA5C3E12, 8'd1, e, b, f);
    chk(f && !e, "R10", "read done without err", {f, e}, 2'b10);
    chk(b, "R11", "cmd_ready low while busy", b, 1);
    check_issue(28'hA5C3E12, 8'd1, 8'h20);
    first = -1;
    for (int i = 0; i < lg_n; i++) if (lg_addr[i] == 3'd0) begin first = i; break; end
    chk(first == 10, "R3", "status polls before data", first - 6, 4);
    chk(first > 0 && lg_addr[first-1] == 3'd7 && lg_data[first-1] == 8'h58,
        "R3", "last poll before data", lg_data[first > 0 ? first-1 : 0], 8'h58);
    chk(count_data(1'b0) == 512, "R5", "data reads per sector", count_data(1'b0), 512);
    chk(rcv_cnt == 512 && rcv_bad == 0, "R5", "read stream bytes", rcv_bad, 0);
    chk(hold_bad == 0 && stalls > 0, "R6", "byte held under backpressure", hold_bad, 0);
    chk(lg_n >= 2 && !lg_wr[lg_n-2] && lg_addr[lg_n-2] == 3'd6 && !lg_wr[lg_n-1] && lg_addr[lg_n-1] == 3'd7,
        "R10", "trailing alt status then status", {lg_addr[lg_n-2], lg_addr[lg_n-1]}, {3'd6, 3'd7});
  endtask

  task automatic t_read_multi();
    bit e, b, f;
    int polls = 0;
    dev_setup(3, 2, 3, 8'h50); bp_on = 0;
    run_cmd(1'b0, 28'h0000101, 8'd3, e, b, f);
    chk(f && !e, "R10", "multi read done", {f, e}, 2'b10);
    for (int i = 0; i < lg_n; i++) if (!lg_wr[i] && lg_addr[i] == 3'd7) polls++;
    chk(polls == 11, "R3", "status reads across three sectors", polls, 11);
    chk(rcv_cnt == 1536 && rcv_bad == 0, "R5", "three sectors of bytes", rcv_cnt, 1536);
  endtask

  task automatic t_write_one();
    bit e, b, f, ok;
    int k;
    dev_setup(1, 1, 1, 8'h50); bp_on = 1;
    run_cmd(1'b1, 28'h0123456, 8'd1, e, b, f);
    chk(f && !e, "R10", "write done without err", {f, e}, 2'b10);
    check_issue(28'h0123456, 8'd1, 8'h30);
    ok = 1; k = 0;
    for (int i = 0; i < lg_n; i++) if (lg_wr[i] && lg_addr[i] == 3'd0) begin
      if (lg_data[i] != wr_pat(k)) ok = 0;
      k++;
    end
    chk(ok && k == 512 && wr_idx == 512, "R7", "written bytes in stream order", k, 512);
    chk(lg_n >= 3 && lg_addr[lg_n-3] == 3'd7 && lg_addr[lg_n-2] == 3'd6 && lg_addr[lg_n-1] == 3'd7,
        "R10", "final status then trailing reads", lg_addr[lg_n-2], 3'd6);
  endtask

  task automatic t_write_err();
    bit e, b, f;
    dev_setup(0, 2, 2, 8'h51); bp_on = 0;
    run_cmd(1'b1, 28'hFFFFFFF, 8'd2, e, b, f);
    chk(f && e, "R9", "err flagged on final status", {f, e}, 2'b11);
    chk(count_data(1'b1) == 1024, "R9", "two sectors written", count_data(1'b1), 1024);
    chk(lg_n > 0 && !lg_wr[lg_n-1] && lg_addr[lg_n-1] == 3'd7 && lg_data[lg_n-1] == 8'h51,
        "R9", "no access after failing status", lg_addr[lg_n-1], 3'd7);
  endtask

  task automatic t_timeout();
    bit e, b, f;
    int t0;
    dev_setup(1000000, 0, 1, 8'h50); bp_on = 0;
    t0 = ticks; tick_en = 1;
    run_cmd(1'b0, 28'h0000042, 8'd1, e, b, f);
    tick_en = 0;
    chk(f && e, "R4", "timeout ends with err", {f, e}, 2'b11);
    chk(ticks - t0 >= 100 && ticks - t0 <= 125, "R4", "ticks before giving up", ticks - t0, 100);
    chk(count_data(1'b0) == 0 && rcv_cnt == 0, "R4", "no data cycles", count_data(1'b0), 0);
    busy_left = 0;
  endtask

  task automatic t_timing();
    chk(viol == 0, "R8", "strobe, select and drive rules", viol, 0);
    chk(min_low >= 3, "R12", "shortest strobe low", min_low, 3);
    chk(min_setup >= 2, "R12", "shortest select-to-strobe", min_setup, 2);
  endtask

  initial begin
    repeat (4) @(negedge clk);
    rst = 1'b0;
    t_reset();
    t_read_one();
    t_read_multi();
    t_write_one();
    t_write_err();
    t_timeout();
    t_timing();
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule